// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that lives in ordinary memory. A request carries the virtual address, and the table base register is sampled when the request is accepted. The walker fetches a first-level descriptor and decodes its two type bits. It then either finishes at once with a 1 MB section or a fault, or it follows a pointer into a coarse or fine second-level table. It fetches one more descriptor from that table and resolves a large, small or tiny page.

Memory is reached through a single-word read port. The request is held with a stable address until the memory answers with a valid strobe. When a walk ends, a one-cycle done strobe comes with the following results, all held until the next walk completes:
- the physical address
- a page-kind code
- the cacheable/bufferable pair
- the domain number
- the access-permission pair for the accessed region
- a fault flag

The block takes a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: The first descriptor read uses the address formed by the table base with bits [13:0] cleared, ORed with virtual address bits [31:20] shifted to positions [13:2].
- R2: A first-level descriptor with type bits [1:0] = 0 ends the walk with a fault after exactly one memory read.
- R3: First-level type 2 is a section. It completes after one read with physical address = descriptor[31:20] concatenated with VA[19:0], page kind 0, and access permission = descriptor[11:10].
- R4: First-level type 1 selects a coarse table. The second read address is descriptor[31:10] with VA[19:12] at positions [9:2].
- R5: First-level type 3 selects a fine table. The second read address is descriptor[31:12] with VA[19:10] at positions [11:2].
- R6: A second-level descriptor with type bits [1:0] = 0 ends the walk with a fault after two reads.
- R7: Second-level type 1 is a large page: physical address = descriptor[31:16] with VA[15:0], and page kind 1. The permission pair is the 2-bit field at descriptor[4+2k +: 2], with k = VA[15:14].
- R8: Second-level type 2 is a small page: physical address = descriptor[31:12] with VA[11:0], and page kind 2. The permission pair is the field at descriptor[4+2k +: 2], with k = VA[11:10].
- R9: Second-level type 3 is a tiny page: physical address = descriptor[31:10] with VA[9:0], page kind 3, and permission = descriptor[5:4].
- R10: The domain always comes from first-level descriptor bits [8:5]. The cacheable/bufferable pair comes from bits [3:2] of the last descriptor read.
- R11: The read request stays high with an unchanged address until the cycle in which read-valid is seen.
- R12: Ready is high only when idle. A request raised while a walk is in progress is ignored and does not change that walk's reads or results.
- R13: Done is high for exactly one cycle per walk, and the fault flag is valid in that cycle. On a fault, the physical address, page kind, cacheable/bufferable pair, domain and permission outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ttb | input | 32 | Translation table base, sampled at request acceptance |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be accepted |
| req_va | input | 32 | Virtual address to translate |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Translation fault |
| pa | output | 32 | Physical address |
| kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain number |
| ap | output | 2 | Access-permission bits |

## Verification
The walker has no parameters: the descriptor format fixes every field position, so the bench builds the single default configuration. It varies the memory response latency instead, from zero to three wait cycles. This exercises the request-hold rule and the one-cycle timing of the done strobe under both back-to-back and stalled reads. Each of the four first-level outcomes is covered, each of the four second-level outcomes is covered, and the subpage selection is checked for more than one index.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ttb,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa,
  output logic [1:0]  kind,
  output logic [1:0]  cb,
  output logic [3:0]  domain,
  output logic [1:0]  ap
);

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} state_t;

  state_t      state;
  logic [19:0] va_q;
  logic [31:0] l1_addr_q, l2_addr_q;
  logic [3:0]  dom_l1_q;
  logic [31:0] pa_q;
  logic [1:0]  kind_q, cb_q, ap_q;
  logic [3:0]  dom_q;
  logic        fault_q;

  logic [1:0]  dtype;
  logic [1:0]  ap_large, ap_small;

  assign dtype = mem_rd_data[1:0];

  always_comb begin
    case (va_q[15:14])
      2'd0:    ap_large = mem_rd_data[5:4];
      2'd1:    ap_large = mem_rd_data[7:6];
      2'd2:    ap_large = mem_rd_data[9:8];
      default: ap_large = mem_rd_data[11:10];
    endcase
    case (va_q[11:10])
      2'd0:    ap_small = mem_rd_data[5:4];
      2'd1:    ap_small = mem_rd_data[7:6];
      2'd2:    ap_small = mem_rd_data[9:8];
      default: ap_small = mem_rd_data[11:10];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      l1_addr_q <= '0;
      l2_addr_q <= '0;
      dom_l1_q  <= '0;
      pa_q      <= '0;
      kind_q    <= '0;
      cb_q      <= '0;
      ap_q      <= '0;
      dom_q     <= '0;
      fault_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q      <= req_va[19:0];
          l1_addr_q <= (ttb & 32'hFFFF_C000) | {18'd0, req_va[31:20], 2'b00};
          state     <= S_L1;
        end
        S_L1: if (mem_rd_valid) begin
          dom_l1_q <= mem_rd_data[8:5];
          case (dtype)
            2'd0: begin
              fault_q <= 1'b1;
              pa_q <= '0; kind_q <= '0; cb_q <= '0; ap_q <= '0; dom_q <= '0;
              state <= S_DONE;
            end
            2'd2: begin
              fault_q <= 1'b0;
              pa_q    <= {mem_rd_data[31:20], va_q[19:0]};
              kind_q  <= 2'd0;
              cb_q    <= mem_rd_data[3:2];
              ap_q    <= mem_rd_data[11:10];
              dom_q   <= mem_rd_data[8:5];
              state   <= S_DONE;
            end
            2'd1: begin
              l2_addr_q <= {mem_rd_data[31:10], va_q[19:12], 2'b00};
              state     <= S_L2;
            end
            default: begin
              l2_addr_q <= {mem_rd_data[31:12], va_q[19:10], 2'b00};
              state     <= S_L2;
            end
          endcase
        end
        S_L2: if (mem_rd_valid) begin
          state <= S_DONE;
          if (dtype == 2'd0) begin
            fault_q <= 1'b1;
            pa_q <= '0; kind_q <= '0; cb_q <= '0; ap_q <= '0; dom_q <= '0;
          end else begin
            fault_q <= 1'b0;
            kind_q  <= dtype;
            cb_q    <= mem_rd_data[3:2];
            dom_q   <= dom_l1_q;
            case (dtype)
              2'd1: begin
                pa_q <= {mem_rd_data[31:16], va_q[15:0]};
                ap_q <= ap_large;
              end
              2'd2: begin
                pa_q <= {mem_rd_data[31:12], va_q[11:0]};
                ap_q <= ap_small;
              end
              default: begin
                pa_q <= {mem_rd_data[31:10], va_q[9:0]};
                ap_q <= mem_rd_data[5:4];
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign mem_rd_req  = (state == S_L1) || (state == S_L2);
  assign mem_rd_addr = (state == S_L2) ? l2_addr_q : l1_addr_q;
  assign done        = (state == S_DONE);
  assign fault       = fault_q;
  assign pa          = pa_q;
  assign kind        = kind_q;
  assign cb          = cb_q;
  assign domain      = dom_q;
  assign ap          = ap_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ttb,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        done,
  input logic        fault,
  input logic [31:0] pa,
  input logic [1:0]  kind,
  input logic [1:0]  cb,
  input logic [3:0]  domain,
  input logic [1:0]  ap,
  input logic [19:0] va_q
);

  a_r1_l1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_req &&
      mem_rd_addr[31:14] == $past(ttb[31:14]) &&
      mem_rd_addr[13:2]  == $past(req_va[31:20]) &&
      mem_rd_addr[1:0]   == 2'b00));

  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r12_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_req);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == 32'd0 && kind == 2'd0 && cb == 2'd0 &&
                         domain == 4'd0 && ap == 2'd0));

  a_r3_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && kind == 2'd0) |-> (pa[19:0] == va_q));

  a_r9_tiny_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && kind == 2'd3) |-> (pa[9:0] == va_q[9:0]));

  a_r7_large_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && kind == 2'd1) |-> (pa[15:0] == va_q[15:0]));

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ttb(ttb), .req_valid(req_valid),
  .req_ready(req_ready), .req_va(req_va), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .done(done),
  .fault(fault), .pa(pa), .kind(kind), .cb(cb), .domain(domain), .ap(ap),
  .va_q(va_q)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ttb = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        done, fault;
  logic [31:0] pa;
  logic [1:0]  kind, cb, ap;
  logic [3:0]  domain;

  int n_chk = 0;
  int n_fail = 0;

  int          lat = 0;
  logic [31:0] m_addr [2];
  logic [31:0] m_data [2];
  int          rd_cnt = 0;
  logic [31:0] rd_log [4];
  int          hold_err = 0;

  always #4 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ttb(ttb), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .done(done), .fault(fault), .pa(pa),
    .kind(kind), .cb(cb), .domain(domain), .ap(ap)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_req) begin
        logic [31:0] a;
        a = mem_rd_addr;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (!mem_rd_req || mem_rd_addr != a) hold_err++;
        end
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        mem_rd_data  = (a == m_addr[0]) ? m_data[0] :
                       (a == m_addr[1]) ? m_data[1] : 32'hDEAD_0000;
        mem_rd_valid = 1'b1;
        @(negedge clk);
        mem_rd_valid = 1'b0;
      end
    end
  end

  function automatic logic [31:0] l1_addr(input logic [31:0] t, input logic [31:0] va);
    return {t[31:14], va[31:20], 2'b00};
  endfunction

  task automatic walk(input logic [31:0] t, input logic [31:0] va, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    hold_err = 0;
    ttb = t;
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      chk(!req_ready, "R12 ready low while busy", {31'd0, req_ready}, 32'd0);
      ttb = 32'hFFFF_FFFF;
      req_va = 32'h5555_5555;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int n = 0; n < 100 && !done; n++) @(negedge clk);
    chk(done, "R13 done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done, "R13 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R12 reset ready", {31'd0, req_ready}, 32'd1);
    chk(done == 1'b0, "R13 reset done", {31'd0, done}, 32'd0);
    chk(mem_rd_req == 1'b0, "R11 reset rd_req", {31'd0, mem_rd_req}, 32'd0);
  endtask

  task automatic t_section();
    logic [31:0] t, va, d;
    t = 32'h1234_5678; va = 32'hABC1_2345;
    d = 32'h7650_0000 | (32'd2 << 10) | (32'd5 << 5) | (32'd3 << 2) | 32'd2;
    m_addr[0] = l1_addr(t, va); m_data[0] = d;
    m_addr[1] = 32'hFFFF_FFF0; m_data[1] = 0;
    lat = 0;
    walk(t, va, 1'b0);
    chk(rd_log[0] == l1_addr(t, va), "R1 l1 address", rd_log[0], l1_addr(t, va));
    chk(rd_cnt == 1, "R3 single read", rd_cnt, 1);
    chk(!fault, "R3 no fault", {31'd0, fault}, 0);
    chk(pa == {d[31:20], va[19:0]}, "R3 section pa", pa, {d[31:20], va[19:0]});
    chk(kind == 2'd0, "R3 kind", {30'd0, kind}, 0);
    chk(ap == 2'd2, "R3 ap", {30'd0, ap}, 2);
    chk(domain == 4'd5, "R10 domain", {28'd0, domain}, 5);
    chk(cb == 2'd3, "R10 cb", {30'd0, cb}, 3);
    after_done();
  endtask

  task automatic t_l1_fault();
    logic [31:0] t, va;
    t = 32'h0000_C000; va = 32'hFFF0_0004;
    m_addr[0] = l1_addr(t, va); m_data[0] = 32'hFFFF_FFFC;
    lat = 2;
    walk(t, va, 1'b0);
    chk(fault, "R2 l1 fault", {31'd0, fault}, 1);
    chk(rd_cnt == 1, "R2 one read", rd_cnt, 1);
    chk(pa == 0 && domain == 0 && cb == 0 && ap == 0, "R13 fault zeros", pa, 0);
    after_done();
  endtask

  task automatic t_coarse_small(input bit poke);
    logic [31:0] t, va, d1, a2, d2;
    t = 32'h8000_0000; va = 32'h0035_6C00;
    d1 = 32'h0040_1C00 | (32'd9 << 5) | 32'd1;
    a2 = {d1[31:10], va[19:12], 2'b00};
    d2 = 32'h9ABC_D000 | (32'd3 << 10) | (32'd2 << 8) | (32'd1 << 6) | (32'd1 << 2) | 32'd2;
    m_addr[0] = l1_addr(t, va); m_data[0] = d1;
    m_addr[1] = a2; m_data[1] = d2;
    lat = 3;
    walk(t, va, poke);
    chk(rd_cnt == 2, "R4 two reads", rd_cnt, 2);
    chk(rd_log[1] == a2, "R4 coarse address", rd_log[1], a2);
    chk(hold_err == 0, "R11 hold during wait", hold_err, 0);
    chk(pa == {d2[31:12], va[11:0]}, "R8 small pa", pa, {d2[31:12], va[11:0]});
    chk(kind == 2'd2, "R8 kind", {30'd0, kind}, 2);
    chk(ap == 2'd3, "R8 subpage ap", {30'd0, ap}, 3);
    chk(domain == 4'd9, "R10 domain from l1", {28'd0, domain}, 9);
    chk(cb == 2'd1, "R10 cb from l2", {30'd0, cb}, 1);
    after_done();
  endtask

  task automatic t_coarse_large();
    logic [31:0] t, va, d1, a2, d2;
    t = 32'h0001_0000; va = 32'h7FF5_8123;
    d1 = 32'h2222_2400 | (32'd15 << 5) | (32'd2 << 2) | 32'd1;
    a2 = {d1[31:10], va[19:12], 2'b00};
    d2 = 32'hBEEF_0000 | (32'd1 << 10) | (32'd2 << 8) | (32'd0 << 6) | (32'd3 << 4) | (32'd2 << 2) | 32'd1;
    m_addr[0] = l1_addr(t, va); m_data[0] = d1;
    m_addr[1] = a2; m_data[1] = d2;
    lat = 1;
    walk(t, va, 1'b0);
    chk(rd_log[0] == l1_addr(t, va), "R1 l1 address", rd_log[0], l1_addr(t, va));
    chk(pa == {d2[31:16], va[15:0]}, "R7 large pa", pa, {d2[31:16], va[15:0]});
    chk(kind == 2'd1, "R7 kind", {30'd0, kind}, 1);
    chk(ap == 2'd2, "R7 subpage ap", {30'd0, ap}, 2);
    chk(domain == 4'd15 && cb == 2'd2, "R10 domain/cb", {26'd0, domain, cb}, {26'd0, 4'd15, 2'd2});
    after_done();
  endtask

  task automatic t_fine_tiny();
    logic [31:0] t, va, d1, a2, d2;
    t = 32'h4444_4000; va = 32'h123A_BCDE;
    d1 = 32'h0ABC_D000 | (32'd3 << 5) | 32'd3;
    a2 = {d1[31:12], va[19:10], 2'b00};
    d2 = 32'h5A5A_5C00 | (32'd3 << 6) | (32'd1 << 4) | (32'd0 << 2) | 32'd3;
    m_addr[0] = l1_addr(t, va); m_data[0] = d1;
    m_addr[1] = a2; m_data[1] = d2;
    lat = 0;
    walk(t, va, 1'b0);
    chk(rd_log[1] == a2, "R5 fine address", rd_log[1], a2);
    chk(pa == {d2[31:10], va[9:0]}, "R9 tiny pa", pa, {d2[31:10], va[9:0]});
    chk(kind == 2'd3, "R9 kind", {30'd0, kind}, 3);
    chk(ap == 2'd1, "R9 ap", {30'd0, ap}, 1);
    chk(domain == 4'd3 && cb == 2'd0, "R10 domain/cb", {26'd0, domain, cb}, {26'd0, 4'd3, 2'd0});
    after_done();
  endtask

  task automatic t_l2_fault();
    logic [31:0] t, va, d1, a2;
    t = 32'h0200_0000; va = 32'h0010_2000;
    d1 = 32'h0300_0400 | (32'd7 << 5) | 32'd1;
    a2 = {d1[31:10], va[19:12], 2'b00};
    m_addr[0] = l1_addr(t, va); m_data[0] = d1;
    m_addr[1] = a2; m_data[1] = 32'hFFFF_FFFC;
    lat = 1;
    walk(t, va, 1'b0);
    chk(fault, "R6 l2 fault", {31'd0, fault}, 1);
    chk(rd_cnt == 2, "R6 two reads", rd_cnt, 2);
    chk(pa == 0 && domain == 0 && kind == 0, "R13 fault zeros", pa, 0);
    after_done();
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL R13 watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_section();
    t_l1_fault();
    t_coarse_small(1'b0);
    t_coarse_large();
    t_fine_tiny();
    t_l2_fault();
    t_coarse_small(1'b1);
    repeat (3) @(negedge clk);
    chk(req_ready, "R12 idle after stray request", {31'd0, req_ready}, 1);
    chk(!mem_rd_req, "R12 stray request not started", {31'd0, mem_rd_req}, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule